// File: doc/BRIEF.md
# Grid Cell Hash Lookup Unit

This unit turns a ray origin into a pointer to the root of a small scene subtree. The scene is cut into a uniform grid whose resolution on every axis is a power of two. A first stage converts each origin component from fixed point into an unsigned N-bit grid coordinate. It subtracts a per-axis offset, multiplies by a per-axis unsigned scale factor and clamps the result into the coordinate range. The top bits of the three coordinates are then joined to form a cell index. That index addresses a table of 32-bit pointers into system memory. Two origins that give the same index lie, by construction, in the same grid cell.

Rays arrive through a valid/ready handshake. A ray is either new, carrying a fixed-point origin that must be scaled, or returning, carrying an integer grid location that skips the scaling stage. Each ray carries a tag, and the tag comes back beside the pointer and cell index on a valid/ready output. Software or a setup engine fills the table through a separate write port before lookups begin, and may update it later.

Top module: `grid_cell_lookup`

## Requirements
- R1: The table holds 2^(XB+YB+ZB) pointers of 32 bits, addressed by a cell index of XB+YB+ZB bits. Every lookup returns the entry stored at the ray's cell index, and that index is also presented on `outCell`.
- R2: The cell index is {top ZB bits of the Z coordinate, top YB bits of Y, top XB bits of X}, with X in the least significant field.
- R3: For a new ray (`inReturn`=0), each coordinate equals floor(((origin − offset) × scale) / 2^FRAC_W). Origin and offset are signed two's complement, and scale is unsigned with FRAC_W fraction bits.
- R4: A scaled coordinate below 0 becomes 0, and one above 2^N−1 becomes 2^N−1, before the cell index is formed.
- R5: For a returning ray (`inReturn`=1), the low N bits of each origin input are the coordinate. Offsets, scales and the upper origin bits have no effect.
- R6: A ray accepted at clock edge k shows `outValid` high after edge k+1. With `outReady` held high, one ray per cycle is accepted and delivered.
- R7: While `outValid` is high and `outReady` is low, `outPtr`, `outTag` and `outCell` hold steady and `inReady` is low. No ray is lost or reordered.
- R8: The tag given with a ray is returned unchanged with that ray's pointer.
- R9: A pulse of `wrEn` writes `wrData` to entry `wrAddr`. A lookup accepted after that write returns the new value.
- R10: During and right after reset, `outValid` is low and `inReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Ray offered |
| inReady | output | 1 | Ray accepted when high with inValid |
| inReturn | input | 1 | 1: origin is already an integer grid location |
| inX | input | ORIG_W | X origin (signed fixed point) or X location |
| inY | input | ORIG_W | Y origin or location |
| inZ | input | ORIG_W | Z origin or location |
| inTag | input | TAG_W | Ray identifier |
| offX | input | ORIG_W | Signed X scene offset |
| offY | input | ORIG_W | Signed Y scene offset |
| offZ | input | ORIG_W | Signed Z scene offset |
| sclX | input | SCALE_W | Unsigned X scale, FRAC_W fraction bits |
| sclY | input | SCALE_W | Unsigned Y scale |
| sclZ | input | SCALE_W | Unsigned Z scale |
| wrEn | input | 1 | Table write strobe |
| wrAddr | input | XB+YB+ZB | Table write index |
| wrData | input | PTR_W | Pointer to store |
| outValid | output | 1 | Result available |
| outReady | input | 1 | Consumer takes the result |
| outPtr | output | PTR_W | Subtree pointer for the ray's cell |
| outTag | output | TAG_W | Tag of the ray |
| outCell | output | XB+YB+ZB | Cell index used for the lookup |

## Verification
The hardest condition to reach is a full pipeline stalled by the consumer while the producer keeps offering rays. In that state both stages hold valid data, `inReady` must drop, and the held result must not change. The bench drives a continuous stream of returning rays while `outReady` follows a repeating pattern with a low cycle in every three. It checks the order and content of everything delivered and requires `inReady` to be low on every stalled cycle. The clamp corners are reached by sweeping new-ray origins across a span wider than the scene on every axis. The offsets and scales are chosen so that each axis crosses both the lower and the upper clamp.

// File: rtl/grid_cell_pkg.sv
package grid_cell_pkg;

  // Strobes issued by the control path to the datapath.
  typedef struct packed {
    logic stage1Load;   // capture the cell index and tag of an accepted ray
    logic stage2Load;   // read the table and capture the result
    logic tableWrite;   // store a pointer in the table
  } gclStrobes_t;

endpackage

// File: rtl/gcl_axis_scale.sv
module gcl_axis_scale #(
  parameter int ORIG_W  = 16,
  parameter int SCALE_W = 16,
  parameter int FRAC_W  = 8,
  parameter int COORD_W = 8
) (
  input  logic signed [ORIG_W-1:0]  origin,
  input  logic signed [ORIG_W-1:0]  offset,
  input  logic        [SCALE_W-1:0] scale,
  input  logic                      bypass,
  output logic        [COORD_W-1:0] coord
);
  localparam int DIFF_W = ORIG_W + 1;
  localparam int PROD_W = DIFF_W + SCALE_W + 1;
  localparam logic [COORD_W-1:0] COORD_MAX = '1;

  logic signed [DIFF_W-1:0] diff;
  logic signed [PROD_W-1:0] diffWide;
  logic signed [PROD_W-1:0] scaleWide;
  logic signed [PROD_W-1:0] product;
  logic signed [PROD_W-1:0] shifted;
  logic        [COORD_W-1:0] clamped;

  always_comb begin
    diff      = $signed({origin[ORIG_W-1], origin}) - $signed({offset[ORIG_W-1], offset});
    diffWide  = $signed({{(SCALE_W+1){diff[DIFF_W-1]}}, diff});
    scaleWide = $signed({{DIFF_W{1'b0}}, 1'b0, scale});
    product   = diffWide * scaleWide;
    shifted   = product >>> FRAC_W;
    if (shifted[PROD_W-1])
      clamped = '0;
    else if (|shifted[PROD_W-2:COORD_W])
      clamped = COORD_MAX;
    else
      clamped = shifted[COORD_W-1:0];
    coord = bypass ? origin[COORD_W-1:0] : clamped;
  end

endmodule

// File: rtl/gcl_ctrl.sv
module gcl_ctrl
  import grid_cell_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        outReady,
  input  logic        wrEn,
  output logic        inReady,
  output logic        outValid,
  output gclStrobes_t strobes
);
  logic stage1Valid;
  logic stage2Valid;
  logic advance;

  assign advance  = !stage2Valid || outReady;
  assign inReady  = advance;
  assign outValid = stage2Valid;

  always_comb begin
    strobes            = '0;
    strobes.stage1Load = advance && inValid;
    strobes.stage2Load = advance && stage1Valid;
    strobes.tableWrite = wrEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1Valid <= 1'b0;
      stage2Valid <= 1'b0;
    end else if (advance) begin
      stage1Valid <= inValid;
      stage2Valid <= stage1Valid;
    end
  end

endmodule

// File: rtl/gcl_datapath.sv
module gcl_datapath
  import grid_cell_pkg::*;
#(
  parameter int ORIG_W  = 16,
  parameter int SCALE_W = 16,
  parameter int FRAC_W  = 8,
  parameter int COORD_W = 8,
  parameter int XB      = 3,
  parameter int YB      = 3,
  parameter int ZB      = 2,
  parameter int PTR_W   = 32,
  parameter int TAG_W   = 4,
  localparam int CELL_W = XB + YB + ZB,
  localparam int CELLS  = 1 << CELL_W
) (
  input  logic                      clk,
  input  gclStrobes_t               strobes,
  input  logic                      inReturn,
  input  logic signed [ORIG_W-1:0]  inX,
  input  logic signed [ORIG_W-1:0]  inY,
  input  logic signed [ORIG_W-1:0]  inZ,
  input  logic        [TAG_W-1:0]   inTag,
  input  logic signed [ORIG_W-1:0]  offX,
  input  logic signed [ORIG_W-1:0]  offY,
  input  logic signed [ORIG_W-1:0]  offZ,
  input  logic        [SCALE_W-1:0] sclX,
  input  logic        [SCALE_W-1:0] sclY,
  input  logic        [SCALE_W-1:0] sclZ,
  input  logic        [CELL_W-1:0]  wrAddr,
  input  logic        [PTR_W-1:0]   wrData,
  output logic        [PTR_W-1:0]   outPtr,
  output logic        [TAG_W-1:0]   outTag,
  output logic        [CELL_W-1:0]  outCell
);
  logic signed [ORIG_W-1:0]  originArr [3];
  logic signed [ORIG_W-1:0]  offsetArr [3];
  logic        [SCALE_W-1:0] scaleArr  [3];
  logic        [COORD_W-1:0] coordArr  [3];

  assign originArr[0] = inX;
  assign originArr[1] = inY;
  assign originArr[2] = inZ;
  assign offsetArr[0] = offX;
  assign offsetArr[1] = offY;
  assign offsetArr[2] = offZ;
  assign scaleArr[0]  = sclX;
  assign scaleArr[1]  = sclY;
  assign scaleArr[2]  = sclZ;

  for (genvar axis = 0; axis < 3; axis++) begin : g_axis
    gcl_axis_scale #(
      .ORIG_W (ORIG_W),
      .SCALE_W(SCALE_W),
      .FRAC_W (FRAC_W),
      .COORD_W(COORD_W)
    ) scale_i (
      .origin(originArr[axis]),
      .offset(offsetArr[axis]),
      .scale (scaleArr[axis]),
      .bypass(inReturn),
      .coord (coordArr[axis])
    );
  end

  // Cell index: Z field highest, X field lowest.
  logic [CELL_W-1:0] cellNow;
  assign cellNow = {coordArr[2][COORD_W-1 -: ZB],
                    coordArr[1][COORD_W-1 -: YB],
                    coordArr[0][COORD_W-1 -: XB]};

  logic [CELL_W-1:0] cellS1;
  logic [TAG_W-1:0]  tagS1;
  logic [PTR_W-1:0]  ptrS2;
  logic [TAG_W-1:0]  tagS2;
  logic [CELL_W-1:0] cellS2;
  logic [PTR_W-1:0]  cellTable [CELLS];

  always_ff @(posedge clk) begin
    if (strobes.stage1Load) begin
      cellS1 <= cellNow;
      tagS1  <= inTag;
    end
    if (strobes.tableWrite)
      cellTable[wrAddr] <= wrData;
    if (strobes.stage2Load) begin
      ptrS2  <= cellTable[cellS1];
      tagS2  <= tagS1;
      cellS2 <= cellS1;
    end
  end

  assign outPtr  = ptrS2;
  assign outTag  = tagS2;
  assign outCell = cellS2;

endmodule

// File: rtl/grid_cell_lookup.sv
module grid_cell_lookup
  import grid_cell_pkg::*;
#(
  parameter int ORIG_W  = 16,
  parameter int SCALE_W = 16,
  parameter int FRAC_W  = 8,
  parameter int COORD_W = 8,
  parameter int XB      = 3,
  parameter int YB      = 3,
  parameter int ZB      = 2,
  parameter int PTR_W   = 32,
  parameter int TAG_W   = 4,
  localparam int CELL_W = XB + YB + ZB
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inValid,
  output logic                      inReady,
  input  logic                      inReturn,
  input  logic signed [ORIG_W-1:0]  inX,
  input  logic signed [ORIG_W-1:0]  inY,
  input  logic signed [ORIG_W-1:0]  inZ,
  input  logic        [TAG_W-1:0]   inTag,
  input  logic signed [ORIG_W-1:0]  offX,
  input  logic signed [ORIG_W-1:0]  offY,
  input  logic signed [ORIG_W-1:0]  offZ,
  input  logic        [SCALE_W-1:0] sclX,
  input  logic        [SCALE_W-1:0] sclY,
  input  logic        [SCALE_W-1:0] sclZ,
  input  logic                      wrEn,
  input  logic        [CELL_W-1:0]  wrAddr,
  input  logic        [PTR_W-1:0]   wrData,
  output logic                      outValid,
  input  logic                      outReady,
  output logic        [PTR_W-1:0]   outPtr,
  output logic        [TAG_W-1:0]   outTag,
  output logic        [CELL_W-1:0]  outCell
);
  gclStrobes_t strobes;

  gcl_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .outReady(outReady),
    .wrEn    (wrEn),
    .inReady (inReady),
    .outValid(outValid),
    .strobes (strobes)
  );

  gcl_datapath #(
    .ORIG_W (ORIG_W),
    .SCALE_W(SCALE_W),
    .FRAC_W (FRAC_W),
    .COORD_W(COORD_W),
    .XB     (XB),
    .YB     (YB),
    .ZB     (ZB),
    .PTR_W  (PTR_W),
    .TAG_W  (TAG_W)
  ) datapath_i (
    .clk     (clk),
    .strobes (strobes),
    .inReturn(inReturn),
    .inX     (inX),
    .inY     (inY),
    .inZ     (inZ),
    .inTag   (inTag),
    .offX    (offX),
    .offY    (offY),
    .offZ    (offZ),
    .sclX    (sclX),
    .sclY    (sclY),
    .sclZ    (sclZ),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .outPtr  (outPtr),
    .outTag  (outTag),
    .outCell (outCell)
  );

endmodule

// File: rtl/gcl_checker.sv
module gcl_checker #(
  parameter int PTR_W  = 32,
  parameter int TAG_W  = 4,
  parameter int CELL_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic [PTR_W-1:0]  outPtr,
  input logic [TAG_W-1:0]  outTag,
  input logic [CELL_W-1:0] outCell
);

  // R10: nothing is presented while reset is held
  always @(posedge clk) begin
    if (!rstN) begin
      a_r10_idle_in_reset: assert (!outValid && inReady)
        else $error("outValid or inReady wrong during reset");
    end
  end

  // R6: an accepted ray is visible on the output two edges later
  a_r6_latency: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> ##1 outValid);

  // R6: a new result only appears for a ray accepted two edges before
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(inValid && inReady, 2));

  // R7: a stalled result holds all its fields
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=>
      (outValid && $stable(outPtr) && $stable(outTag) && $stable(outCell)));

  // R7: no new ray is taken while the output stage is blocked
  a_r7_block_input: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);

endmodule

bind grid_cell_lookup gcl_checker #(
  .PTR_W (PTR_W),
  .TAG_W (TAG_W),
  .CELL_W(CELL_W)
) checker_i (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .inReady (inReady),
  .outValid(outValid),
  .outReady(outReady),
  .outPtr  (outPtr),
  .outTag  (outTag),
  .outCell (outCell)
);

// File: tb/grid_cell_lookup_tb_top.sv
module grid_cell_lookup_tb_top;
  localparam int ORIG_W  = 16;
  localparam int SCALE_W = 16;
  localparam int FRAC_W  = 8;
  localparam int COORD_W = 8;
  localparam int XB = 3, YB = 3, ZB = 2;
  localparam int PTR_W = 32, TAG_W = 4;
  localparam int CELL_W = XB + YB + ZB;
  localparam int CELLS  = 1 << CELL_W;
  localparam int CMAX   = (1 << COORD_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inReturn = 1'b0, wrEn = 1'b0, outReady = 1'b0;
  logic signed [ORIG_W-1:0] inX = '0, inY = '0, inZ = '0;
  logic signed [ORIG_W-1:0] offX = '0, offY = '0, offZ = '0;
  logic [SCALE_W-1:0] sclX = '0, sclY = '0, sclZ = '0;
  logic [TAG_W-1:0] inTag = '0;
  logic [CELL_W-1:0] wrAddr = '0;
  logic [PTR_W-1:0] wrData = '0;
  logic inReady, outValid;
  logic [PTR_W-1:0] outPtr;
  logic [TAG_W-1:0] outTag;
  logic [CELL_W-1:0] outCell;

  int nTests = 0, nFail = 0, cycles = 0;

  always #10 clk = ~clk;

  grid_cell_lookup dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inReturn(inReturn), .inX(inX), .inY(inY), .inZ(inZ), .inTag(inTag),
    .offX(offX), .offY(offY), .offZ(offZ), .sclX(sclX), .sclY(sclY), .sclZ(sclZ),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .outValid(outValid),
    .outReady(outReady), .outPtr(outPtr), .outTag(outTag), .outCell(outCell)
  );

  function automatic logic [PTR_W-1:0] tblVal(int a);
    return 32'hA500_0000 ^ PTR_W'(a * 32'h0001_0101);
  endfunction

  function automatic int expCoord(int o, int off, int s);
    int q;
    q = ((o - off) * s) >>> FRAC_W;
    if (q < 0) q = 0;
    if (q > CMAX) q = CMAX;
    return q;
  endfunction

  function automatic int cellOf(int x, int y, int z);
    return ((z >> (COORD_W - ZB)) << (XB + YB)) | ((y >> (COORD_W - YB)) << XB)
           | (x >> (COORD_W - XB));
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeEntry(input int a, input logic [PTR_W-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = CELL_W'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Send one ray into an empty pipeline and check latency, pointer, cell and tag.
  task automatic sendOne(input bit ret, input int x, input int y, input int z,
                         input int tag, input int expCell, input logic [PTR_W-1:0] expPtr,
                         input string req);
    @(negedge clk);
    inValid = 1'b1; inReturn = ret; outReady = 1'b1;
    inX = ORIG_W'(x); inY = ORIG_W'(y); inZ = ORIG_W'(z); inTag = TAG_W'(tag);
    @(negedge clk);
    inValid = 1'b0;
    chk(outValid == 1'b0, "R6 early", longint'(outValid), 0);
    @(negedge clk);
    chk(outValid == 1'b1, "R6 latency", longint'(outValid), 1);
    chk(outCell == CELL_W'(expCell), {req, " cell"}, longint'(outCell), longint'(expCell));
    chk(outPtr == expPtr, {req, " R1 ptr"}, longint'(outPtr), longint'(expPtr));
    chk(outTag == TAG_W'(tag), "R8 tag", longint'(outTag), longint'(tag));
  endtask

  initial begin : watchdog
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    nFail++; nTests++;
    $display("FAIL watchdog actual=%0d expected=<100000", cycles);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(outValid == 1'b0, "R10 outValid", longint'(outValid), 0);
    chk(inReady == 1'b1, "R10 inReady", longint'(inReady), 1);
    rstN = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b0, "R10 after reset", longint'(outValid), 0);

    // R9 fill the table
    for (int a = 0; a < CELLS; a++) writeEntry(a, tblVal(a));

    // R2 R5 exhaustive sweep over every cell with returning rays;
    // offsets/scales and upper origin bits are junk that must be ignored.
    offX = 16'sd1234; offY = -16'sd777; offZ = 16'sd42;
    sclX = 16'h0333; sclY = 16'h0011; sclZ = 16'h7FFF;
    for (int c = 0; c < CELLS; c++) begin
      int xc, yc, zc, x, y, z;
      xc = c & 7; yc = (c >> 3) & 7; zc = c >> 6;
      x = (xc << 5) | ((c * 5) & 31);
      y = (yc << 5) | ((c * 11) & 31);
      z = (zc << 6) | ((c * 13) & 63);
      sendOne(1'b1, x | 16'hA700, y | 16'h5B00, z | 16'hC300, c & 15,
              c, tblVal(c), "R2 R5 returning");
    end

    // R3 R4 scaled sweep crossing both clamps on every axis
    offX = -16'sd200; offY = 16'sd50; offZ = -16'sd1000;
    sclX = 16'h0180; sclY = 16'h0100; sclZ = 16'h0040;
    for (int i = 0; i < 64; i++) begin
      int ox, oy, oz, c;
      ox = -400 + i * 9; oy = -100 + i * 7; oz = -2000 + i * 97;
      c = cellOf(expCoord(ox, -200, 384), expCoord(oy, 50, 256), expCoord(oz, -1000, 64));
      sendOne(1'b0, ox, oy, oz, i & 15, c, tblVal(c), "R3 R4 scaled");
    end
    // R4 explicit extremes
    sendOne(1'b0, -32768, -32768, -32768, 3, 0, tblVal(0), "R4 low clamp");
    sendOne(1'b0, 32767, 32767, 32767, 4, CELLS - 1, tblVal(CELLS - 1), "R4 high clamp");

    // R9 rewrite an entry and look it up
    writeEntry(77, 32'hDEAD_BEEF);
    sendOne(1'b1, (77 & 7) << 5, ((77 >> 3) & 7) << 5, (77 >> 6) << 6, 9, 77,
            32'hDEAD_BEEF, "R9 rewrite");

    // R6 R7 stream with a stalling consumer
    begin
      int sent, got, cyc;
      bit accPrev;
      sent = 0; got = 0; accPrev = 0;
      for (cyc = 0; cyc < 80; cyc++) begin
        @(negedge clk);
        if (accPrev) sent++;
        outReady = (cyc % 3) != 1;
        if (sent < 12) begin
          int c;
          c = (sent * 21 + 5) % CELLS;
          inValid = 1'b1; inReturn = 1'b1; inTag = TAG_W'(sent);
          inX = ORIG_W'((c & 7) << 5); inY = ORIG_W'(((c >> 3) & 7) << 5);
          inZ = ORIG_W'((c >> 6) << 6);
        end else inValid = 1'b0;
        #1;
        accPrev = inValid && inReady;
        if (outValid && !outReady)
          chk(inReady == 1'b0, "R7 inReady stall", longint'(inReady), 0);
        if (outValid && outReady) begin
          int ec;
          ec = (got * 21 + 5) % CELLS;
          chk(outTag == TAG_W'(got), "R7 order tag", longint'(outTag), longint'(got));
          chk(outPtr == tblVal(ec), "R7 order ptr", longint'(outPtr), longint'(tblVal(ec)));
          got++;
        end
      end
      inValid = 1'b0;
      chk(got == 12, "R7 count", longint'(got), 12);
    end

    // R6 full throughput: 6 rays in 6 consecutive cycles with outReady high
    begin
      int got, firstCyc, lastCyc;
      got = 0; firstCyc = -1; lastCyc = -1;
      outReady = 1'b1;
      for (int cyc = 0; cyc < 12; cyc++) begin
        @(negedge clk);
        if (cyc < 6) begin
          inValid = 1'b1; inReturn = 1'b1; inTag = TAG_W'(cyc);
          inX = ORIG_W'(cyc << 5); inY = '0; inZ = '0;
        end else inValid = 1'b0;
        #1;
        if (cyc < 6) chk(inReady == 1'b1, "R6 ready", longint'(inReady), 1);
        if (outValid) begin
          if (firstCyc < 0) firstCyc = cyc;
          lastCyc = cyc;
          chk(outPtr == tblVal(got), "R6 stream ptr", longint'(outPtr), longint'(tblVal(got)));
          got++;
        end
      end
      chk(got == 6, "R6 stream count", longint'(got), 6);
      chk(lastCyc - firstCyc == 5, "R6 back to back", longint'(lastCyc - firstCyc), 5);
    end

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule